// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit performs one addition or subtraction on every lane of a 32-bit packed word in a single pass. A word holds either four 8-bit lanes or two 16-bit lanes. Each lane is computed on its own, and no carry passes between lanes. The same operation, selected by the add/subtract input, applies to all lanes. A three-bit mode code picks one of six ways to shape each lane result: wrap-around, saturation or halving, each in a signed or an unsigned flavour.

The wrap-around modes also produce a greater-or-equal flag vector with one bit per byte position. The other modes leave the flags as they were. A single register stage captures the operands when the input valid is high and presents the result, flags and output valid one clock later. A surrounding datapath can therefore issue one operation per cycle.

Top module: `packed_simd_addsub`

## Requirements
- R1: `lane_sel`=0 splits each word into four 8-bit lanes, where lane i is bits [8i+7:8i]. `lane_sel`=1 splits it into two 16-bit lanes, where lane j is bits [16j+15:16j]. No carry or borrow crosses a lane boundary. `sub_sel`=1 computes a minus b per lane, and `sub_sel`=0 computes a plus b.
- R2: Mode code 0 (signed wrap) and mode code 1 (unsigned wrap) return each lane result modulo 2^8 or 2^16. Codes 6 and 7 are never applied.
- R3: Mode code 2 (signed saturate) clamps an overflowing lane to the most positive or most negative two's-complement value of the lane width.
- R4: Mode code 3 (unsigned saturate) clamps a lane that goes above the maximum to all ones, and a lane that goes below zero to zero.
- R5: Mode code 4 (signed halve) and mode code 5 (unsigned halve) take the exact result one bit wider than the lane. They shift it right by one, arithmetically for code 4 and logically for code 5, and never overflow. For unsigned subtraction, the extra bit is the borrow.
- R6: In modes 0 and 1, `ge_flags[i]` belongs to byte position i. For unsigned add it is the lane carry out. For unsigned subtract it is set when no borrow occurs. For signed operations it is set when the exact result is at least zero.
- R7: With 16-bit lanes in a wrap mode, both flag bits of a lane's two byte positions take that lane's single flag value.
- R8: Modes 2 to 5 leave `ge_flags` holding its previous registered value.
- R9: Operands are captured on a rising edge with `in_valid` high. Result and flags appear after that edge, and `out_valid` equals `in_valid` delayed by one cycle.
- R10: While `in_valid` is low, `result` and `ge_flags` hold their values.
- R11: A synchronous active-high `rst` clears `out_valid`, `result` and `ge_flags` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid, capture this cycle |
| op_a | input | 32 | Packed first operand |
| op_b | input | 32 | Packed second operand |
| lane_sel | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| sub_sel | input | 1 | 0: add, 1: subtract |
| mode_sel | input | 3 | Result mode code 0..5 |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Packed lane results |
| ge_flags | output | 4 | Greater-or-equal flag per byte position |

## Verification
The checker assumes that a mode code of 6 or 7 never arrives while `in_valid` is high, and it flags any such cycle. The bench draws every operation from codes 0 to 5. The flag-pairing and flag-hold properties rely on `lane_sel` and `mode_sel` being sampled in the same cycle as `in_valid`. The stimulus changes these controls only at falling edges, so every capture sees one consistent operation.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [2:0] {
        MD_WRAP_S = 3'd0,
        MD_WRAP_U = 3'd1,
        MD_SAT_S  = 3'd2,
        MD_SAT_U  = 3'd3,
        MD_HALF_S = 3'd4,
        MD_HALF_U = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        SHAPE_WRAP = 2'd0,
        SHAPE_SAT  = 2'd1,
        SHAPE_HALF = 2'd2
    } shape_e;

    typedef struct packed {
        logic   is_signed;
        logic   sub;
        shape_e shape;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [2:0] code, input logic sub);
        op_ctl_t c;
        c.is_signed = ~code[0];
        c.sub       = sub;
        case (code[2:1])
            2'd1:    c.shape = SHAPE_SAT;
            2'd2:    c.shape = SHAPE_HALF;
            default: c.shape = SHAPE_WRAP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  simd_pkg::op_ctl_t ctl,
    output logic [W-1:0]     res,
    output logic             ge
);
    import simd_pkg::*;

    localparam int XW = W + 2;

    logic [XW-1:0] xa, xb, full;
    logic [2:0]    top3;
    logic          s_ovf;
    logic [W-1:0]  s_max, s_min;

    assign s_max = {1'b0, {(W-1){1'b1}}};
    assign s_min = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        xa    = ctl.is_signed ? {{2{a[W-1]}}, a} : {2'b00, a};
        xb    = ctl.is_signed ? {{2{b[W-1]}}, b} : {2'b00, b};
        full  = ctl.sub ? (xa - xb) : (xa + xb);
        top3  = full[XW-1:W-1];
        s_ovf = (top3 != 3'b000) && (top3 != 3'b111);

        res = full[W-1:0];
        case (ctl.shape)
            SHAPE_SAT: begin
                if (ctl.is_signed) begin
                    if (s_ovf) res = full[XW-1] ? s_min : s_max;
                end else begin
                    if (full[XW-1])  res = '0;
                    else if (full[W]) res = '1;
                end
            end
            SHAPE_HALF: res = full[W:1];
            default:    res = full[W-1:0];
        endcase

        if (ctl.is_signed || ctl.sub) ge = ~full[XW-1];
        else                          ge = full[W];
    end

endmodule

// File: rtl/simd_addsub_core.sv
module simd_addsub_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                wide,
    input  simd_pkg::op_ctl_t   ctl,
    output logic [DATA_W-1:0]   res,
    output logic [DATA_W/8-1:0] ge
);
    localparam int NB = DATA_W / 8;
    localparam int NH = DATA_W / 16;

    logic [DATA_W-1:0] res_b, res_h;
    logic [NB-1:0]     ge_b, ge_h_spread;
    logic [NH-1:0]     ge_h;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        simd_lane_unit #(.W(8)) u_lane (
            .a   (a[8*i +: 8]),
            .b   (b[8*i +: 8]),
            .ctl (ctl),
            .res (res_b[8*i +: 8]),
            .ge  (ge_b[i])
        );
        assign ge_h_spread[i] = ge_h[i/2];
    end

    for (genvar j = 0; j < NH; j++) begin : g_half
        simd_lane_unit #(.W(16)) u_lane (
            .a   (a[16*j +: 16]),
            .b   (b[16*j +: 16]),
            .ctl (ctl),
            .res (res_h[16*j +: 16]),
            .ge  (ge_h[j])
        );
    end

    assign res = wide ? res_h : res_b;
    assign ge  = wide ? ge_h_spread : ge_b;

endmodule

// File: rtl/packed_simd_addsub.sv
module packed_simd_addsub #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic                lane_sel,
    input  logic                sub_sel,
    input  logic [2:0]          mode_sel,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [DATA_W/8-1:0] ge_flags
);
    import simd_pkg::*;

    localparam int GE_W = DATA_W / 8;

    op_ctl_t           ctl;
    logic [DATA_W-1:0] res_d;
    logic [GE_W-1:0]   ge_d;
    logic              ge_upd;

    assign ctl    = decode_op(mode_sel, sub_sel);
    assign ge_upd = (ctl.shape == SHAPE_WRAP);

    simd_addsub_core #(.DATA_W(DATA_W)) u_core (
        .a    (op_a),
        .b    (op_b),
        .wide (lane_sel),
        .ctl  (ctl),
        .res  (res_d),
        .ge   (ge_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            ge_flags  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_d;
                if (ge_upd) ge_flags <= ge_d;
            end
        end
    end

endmodule

// File: rtl/packed_simd_addsub_chk.sv
module packed_simd_addsub_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [DATA_W-1:0]   op_a,
    input logic [DATA_W-1:0]   op_b,
    input logic                lane_sel,
    input logic                sub_sel,
    input logic [2:0]          mode_sel,
    input logic                out_valid,
    input logic [DATA_W-1:0]   result,
    input logic [DATA_W/8-1:0] ge_flags
);
    localparam int NB = DATA_W / 8;

    function automatic logic bytes_not_below(input logic [DATA_W-1:0] r, input logic [DATA_W-1:0] a);
        logic ok = 1'b1;
        for (int i = 0; i < NB; i++)
            if (r[8*i +: 8] < a[8*i +: 8]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic pairs_equal(input logic [DATA_W/8-1:0] g);
        logic ok = 1'b1;
        for (int i = 0; i < NB; i += 2)
            if (g[i] != g[i+1]) ok = 1'b0;
        return ok;
    endfunction

    // R2: input assumption, reserved codes never issued
    a_r2_mode_legal: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (mode_sel <= 3'd5));

    a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_valid_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(ge_flags)));

    a_r8_ge_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel >= 3'd2) |=> $stable(ge_flags));

    a_r7_ge_pairs: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sel && mode_sel <= 3'd1) |=> pairs_equal(ge_flags));

    a_r4_usat_add_floor: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel == 3'd3 && !sub_sel && !lane_sel)
        |=> bytes_not_below(result, $past(op_a)));

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && ge_flags == '0));

endmodule

bind packed_simd_addsub packed_simd_addsub_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/packed_simd_addsub_tb_top.sv
module packed_simd_addsub_tb_top;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        wide;
        logic        sub;
        logic [2:0]  mode;
        logic [31:0] exp_res;
        logic [3:0]  exp_ge;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h7F8001FF, 32'h0180FF01, 1'b0, 1'b0, 3'd0, 32'h80000000, 4'hB},
        '{32'h7F8001FF, 32'h0180FF01, 1'b0, 1'b0, 3'd1, 32'h80000000, 4'h7},
        '{32'h100500FF, 32'h100601FE, 1'b0, 1'b1, 3'd1, 32'h00FFFF01, 4'h9},
        '{32'h7FFF0005, 32'hFFFF0007, 1'b1, 1'b1, 3'd0, 32'h8000FFFE, 4'hC},
        '{32'h7F8010F0, 32'h01FF20F0, 1'b0, 1'b0, 3'd2, 32'h7F8030E0, 4'hC},
        '{32'h05FF1000, 32'h06000801, 1'b0, 1'b1, 3'd3, 32'h00FF0800, 4'hC},
        '{32'hFFFF1234, 32'h00010001, 1'b1, 1'b0, 3'd3, 32'hFFFF1235, 4'hC},
        '{32'h80007FFF, 32'h0001FFFF, 1'b1, 1'b1, 3'd2, 32'h80007FFF, 4'hC},
        '{32'h807FFF03, 32'h807FFE04, 1'b0, 1'b0, 3'd4, 32'h807FFE03, 4'hC},
        '{32'h00FF1003, 32'h01002001, 1'b0, 1'b1, 3'd5, 32'hFF7FF801, 4'hC},
        '{32'hFFFF0001, 32'hFFFF0002, 1'b1, 1'b0, 3'd5, 32'hFFFF0001, 4'hC},
        '{32'h80000001, 32'h7FFF0002, 1'b1, 1'b1, 3'd4, 32'h8000FFFF, 4'hC},
        '{32'h00010002, 32'h00020002, 1'b1, 1'b1, 3'd1, 32'hFFFF0000, 4'h3},
        '{32'h00000000, 32'h01FF807F, 1'b0, 1'b1, 3'd0, 32'hFF018081, 4'h6},
        '{32'h8000FFFF, 32'h80000001, 1'b1, 1'b0, 3'd1, 32'h00000000, 4'hF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        lane_sel = 1'b0;
    logic        sub_sel = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  ge_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    packed_simd_addsub #(.DATA_W(32)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .lane_sel  (lane_sel),
        .sub_sel   (sub_sel),
        .mode_sel  (mode_sel),
        .out_valid (out_valid),
        .result    (result),
        .ge_flags  (ge_flags)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [2:0] m);
        case (m)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3";
            3'd3:       return "R4";
            default:    return "R5";
        endcase
    endfunction

    function automatic string ge_tag(input logic [2:0] m, input logic w);
        if (m >= 3'd2) return "R8";
        return w ? "R7" : "R6";
    endfunction

    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic w, input logic s, input logic [2:0] m);
        op_a = a; op_b = b; lane_sel = w; sub_sel = s; mode_sel = m;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: state after reset
        check("R11 out_valid", {31'b0, out_valid}, 32'd0);
        check("R11 result", result, 32'd0);
        check("R11 ge_flags", {28'b0, ge_flags}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].a, VECS[k].b, VECS[k].wide, VECS[k].sub, VECS[k].mode);
            check({res_tag(VECS[k].mode), " result"}, result, VECS[k].exp_res);
            check({ge_tag(VECS[k].mode, VECS[k].wide), " ge_flags"},
                  {28'b0, ge_flags}, {28'b0, VECS[k].exp_ge});
            check("R9 out_valid", {31'b0, out_valid}, 32'd1);
        end

        // R10 / R9: idle cycles keep outputs, drop valid
        in_valid = 1'b0;
        op_a = 32'h12345678; op_b = 32'h9ABCDEF0; mode_sel = 3'd0;
        @(negedge clk);
        check("R9 out_valid idle", {31'b0, out_valid}, 32'd0);
        check("R10 result idle", result, 32'h00000000);
        check("R10 ge_flags idle", {28'b0, ge_flags}, 32'hF);
        @(negedge clk);
        check("R10 result idle2", result, 32'h00000000);

        // R1: same operands, byte lanes versus halfword lanes
        issue(32'h00FF00FF, 32'h00010001, 1'b0, 1'b0, 3'd1);
        check("R1 byte lanes result", result, 32'h00000000);
        check("R1 byte lanes ge", {28'b0, ge_flags}, 32'h5);
        issue(32'h00FF00FF, 32'h00010001, 1'b1, 1'b0, 3'd1);
        check("R1 half lanes result", result, 32'h01000100);
        check("R1 half lanes ge", {28'b0, ge_flags}, 32'h0);

        // R11: reset while busy clears everything
        issue(32'h00000000, 32'h00000000, 1'b0, 1'b0, 3'd0);
        check("R6 zero sum ge", {28'b0, ge_flags}, 32'hF);
        rst = 1'b1;
        issue(32'h11111111, 32'h11111111, 1'b0, 1'b0, 3'd0);
        check("R11 busy out_valid", {31'b0, out_valid}, 32'd0);
        check("R11 busy ge", {28'b0, ge_flags}, 32'd0);
        check("R11 busy result", result, 32'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule